// File: doc/BRIEF.md
# PWM Channel Status and Command Register

This block is the 16-bit control word of one PWM generator channel, sitting on a simple synchronous register bus with an address, a write enable, write data and a combinational read path. Within a single word it combines four access kinds. There are sticky event flags for four protection and control inputs: sync, fault, current limit and feed-forward. There are live level bits for the same four inputs. There are write-one command bits that always read back as zero. Finally, there are status bits that hardware sets and software may clear.

The PWM counter and output stage sit outside the block. They supply a cycle-end pulse, a half-cycle indication and the running time-base value. They receive from the block start and stop requests, a one-cycle strobe that copies buffered data into the active registers, and a lock level that blocks writes to the user data registers while an update is pending. A software capture handshake copies the time-base value into a capture register. Software reads that register at a second address.

Top module: `pwm_stat_reg`

## Requirements
- R1: After reset, the status word, the capture register, startReq, stopReq, loadStrobe and dataLock all read 0.
- R2: The event flags sit at bits 15 (sync), 14 (fault), 13 (current limit) and 12 (feed-forward). While enable is high, a flag sets on a rising edge of its input. It also sets when its input is already high in the cycle enable rises. While enable is low, a flag never sets.
- R3: Bits 11, 10, 9 and 8 show the present levels of syncIn, faultIn, climIn and ffwdIn.
- R4: Software clears bits 15..12 and bit 5 by writing 0 to them at the status address (0). Writing 1 leaves them unchanged. When a hardware set and a software clear land in the same cycle, the bit ends up set.
- R5: Writing 1 to bit 7 pulses startReq for one cycle after the write and sets bit 0 (triggered). Bit 7 reads 0.
- R6: Writing 1 to bit 6 pulses stopReq for one cycle after the write and clears bit 0. If bits 7 and 6 are written as 1 together, the stop wins. Bit 6 reads 0.
- R7: Writing 1 to bit 5 while it reads 0 requests a capture. On the clock after the write, timeBase is latched into the capture register, which is readable at address 1, and bit 5 sets.
- R8: While bit 5 is set, further capture requests are ignored and the capture register holds its value until software clears bit 5.
- R9: Writing 1 to bit 3 sets bit 4 (update pending) and raises dataLock. Bit 3 reads 0.
- R10: A cycleEnd pulse while bit 4 is set clears bit 4 and dataLock, and pulses loadStrobe for one cycle. A cycleEnd pulse with no update pending leaves loadStrobe low.
- R11: Bit 2 toggles on every cycleEnd while pushPull is high. It clears one clock after pushPull goes low and then stays 0.
- R12: Bit 1 shows halfIn from the previous clock while centerMode is high, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register bus select |
| wrEn | input | 1 | Register bus write enable |
| addr | input | ADDR_W | Register address (0 status, 1 capture) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational on addr |
| enable | input | 1 | Channel enable |
| syncIn | input | 1 | Sync input level |
| faultIn | input | 1 | Fault input level |
| climIn | input | 1 | Current-limit input level |
| ffwdIn | input | 1 | Feed-forward input level |
| cycleEnd | input | 1 | One-cycle pulse at the end of a PWM cycle |
| pushPull | input | 1 | Push-pull mode selected |
| centerMode | input | 1 | Center-aligned mode selected |
| halfIn | input | 1 | Time base is in its second half |
| timeBase | input | TB_W | Running time-base value |
| startReq | output | 1 | One-cycle start request to the generator |
| stopReq | output | 1 | One-cycle stop request to the generator |
| loadStrobe | output | 1 | One-cycle copy strobe for buffered data |
| dataLock | output | 1 | User data registers are write-blocked |
| capValue | output | TB_W | Captured time-base value |

## Verification
A hardware event set and a software clear can hit the same event flag in one cycle. The bench provokes this by raising ffwdIn on the same clock edge that a status write puts 0 into every flag. It then expects bit 12 to read 1 while the other flags read 0. A second collision is a simultaneous start and stop command, which is judged by a stopReq pulse and bit 0 left clear. A third is a capture request that arrives while a capture is already held, which is judged by an unchanged capture register.

// File: rtl/pwm_stat_pkg.sv
package pwm_stat_pkg;

  // Status word bit positions that software decodes
  localparam int STAT_W     = 16;
  localparam int EVT_LSB    = 12;
  localparam int LIVE_LSB   = 8;
  localparam int B_TRGSET   = 7;
  localparam int B_TRGCLR   = 6;
  localparam int B_CAP      = 5;
  localparam int B_UPDPEND  = 4;
  localparam int B_UPDREQ   = 3;
  localparam int B_STEER    = 2;
  localparam int B_HALF     = 1;
  localparam int B_TRIG     = 0;
  localparam int NUM_EVT    = 4;

  // Strobes from the bus decoder into the datapath
  typedef struct packed {
    logic                statWr;   // any write to the status address
    logic                trigSet;
    logic                trigClr;
    logic                capReq;
    logic                capClr;
    logic                updReq;
    logic [NUM_EVT-1:0]  evtKeep;  // 0 in a bit clears that event flag
  } ctrlStrobe_t;

endpackage

// File: rtl/pwm_stat_ctrl.sv
module pwm_stat_ctrl
  import pwm_stat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sel,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [STAT_W-1:0]  wrData,
  output ctrlStrobe_t        strobe,
  output logic               startReq,
  output logic               stopReq
);

  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);

  logic statHit;

  assign statHit = sel && wrEn && (addr == STAT_SEL);

  always_comb begin
    strobe          = '0;
    strobe.statWr   = statHit;
    strobe.trigClr  = statHit && wrData[B_TRGCLR];
    strobe.trigSet  = statHit && wrData[B_TRGSET] && !wrData[B_TRGCLR];
    strobe.capReq   = statHit && wrData[B_CAP];
    strobe.capClr   = statHit && !wrData[B_CAP];
    strobe.updReq   = statHit && wrData[B_UPDREQ];
    strobe.evtKeep  = wrData[EVT_LSB +: NUM_EVT];
  end

  // Command pulses to the generator, one cycle after the write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReq <= 1'b0;
      stopReq  <= 1'b0;
    end else begin
      startReq <= strobe.trigSet;
      stopReq  <= strobe.trigClr;
    end
  end

endmodule

// File: rtl/pwm_stat_dp.sv
module pwm_stat_dp
  import pwm_stat_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                enable,
  input  logic [NUM_EVT-1:0]  evtIn,      // [3]=sync [2]=fault [1]=clim [0]=ffwd
  input  logic                cycleEnd,
  input  logic                pushPull,
  input  logic                centerMode,
  input  logic                halfIn,
  input  logic [TB_W-1:0]     timeBase,
  output logic [STAT_W-1:0]   statWord,
  output logic [TB_W-1:0]     capValue,
  output logic                loadStrobe,
  output logic                dataLock
);

  logic [NUM_EVT-1:0] evtQ;
  logic [NUM_EVT-1:0] inPrev;
  logic               enPrev;
  logic               trigQ;
  logic               capQ;
  logic               capPend;
  logic               updQ;
  logic               steerQ;
  logic               halfQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPrev <= '0;
      enPrev <= 1'b0;
    end else begin
      inPrev <= evtIn;
      enPrev <= enable;
    end
  end

  // One sticky flag per input
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic riseHit;
    assign riseHit = enable && evtIn[i] && (!inPrev[i] || !enPrev);
    always_ff @(posedge clk) begin
      if (!rstN)
        evtQ[i] <= 1'b0;
      else if (riseHit)
        evtQ[i] <= 1'b1;
      else if (strobe.statWr && !strobe.evtKeep[i])
        evtQ[i] <= 1'b0;
    end
  end

  // Trigger state: stop has priority
  always_ff @(posedge clk) begin
    if (!rstN)
      trigQ <= 1'b0;
    else if (strobe.trigClr)
      trigQ <= 1'b0;
    else if (strobe.trigSet)
      trigQ <= 1'b1;
  end

  // Capture handshake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ     <= 1'b0;
      capPend  <= 1'b0;
      capValue <= '0;
    end else begin
      if (capPend) begin
        capPend  <= 1'b0;
        capQ     <= 1'b1;
        capValue <= timeBase;
      end else begin
        if (strobe.capReq && !capQ)
          capPend <= 1'b1;
        if (strobe.capClr)
          capQ <= 1'b0;
      end
    end
  end

  // Update request / pending / load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updQ       <= 1'b0;
      loadStrobe <= 1'b0;
    end else begin
      loadStrobe <= updQ && cycleEnd;
      if (updQ && cycleEnd)
        updQ <= 1'b0;
      else if (strobe.updReq)
        updQ <= 1'b1;
    end
  end

  // Push-pull steering and half-cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      steerQ <= 1'b0;
      halfQ  <= 1'b0;
    end else begin
      if (!pushPull)
        steerQ <= 1'b0;
      else if (cycleEnd)
        steerQ <= !steerQ;
      halfQ <= centerMode && halfIn;
    end
  end

  assign dataLock = updQ;

  always_comb begin
    statWord                          = '0;
    statWord[EVT_LSB +: NUM_EVT]      = evtQ;
    statWord[LIVE_LSB +: NUM_EVT]     = evtIn;
    statWord[B_CAP]                   = capQ;
    statWord[B_UPDPEND]               = updQ;
    statWord[B_STEER]                 = steerQ;
    statWord[B_HALF]                  = halfQ;
    statWord[B_TRIG]                  = trigQ;
  end

endmodule

// File: rtl/pwm_stat_reg.sv
module pwm_stat_reg
  import pwm_stat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CAP_ADDR  = 1,
  parameter int TB_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sel,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [15:0]        wrData,
  output logic [15:0]        rdData,
  input  logic               enable,
  input  logic               syncIn,
  input  logic               faultIn,
  input  logic               climIn,
  input  logic               ffwdIn,
  input  logic               cycleEnd,
  input  logic               pushPull,
  input  logic               centerMode,
  input  logic               halfIn,
  input  logic [TB_W-1:0]    timeBase,
  output logic               startReq,
  output logic               stopReq,
  output logic               loadStrobe,
  output logic               dataLock,
  output logic [TB_W-1:0]    capValue
);

  localparam logic [ADDR_W-1:0] CAP_SEL = ADDR_W'(CAP_ADDR);

  ctrlStrobe_t       strobe;
  logic [STAT_W-1:0] statWord;

  pwm_stat_ctrl #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .strobe   (strobe),
    .startReq (startReq),
    .stopReq  (stopReq)
  );

  pwm_stat_dp #(
    .TB_W (TB_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .enable     (enable),
    .evtIn      ({syncIn, faultIn, climIn, ffwdIn}),
    .cycleEnd   (cycleEnd),
    .pushPull   (pushPull),
    .centerMode (centerMode),
    .halfIn     (halfIn),
    .timeBase   (timeBase),
    .statWord   (statWord),
    .capValue   (capValue),
    .loadStrobe (loadStrobe),
    .dataLock   (dataLock)
  );

  always_comb begin
    rdData = '0;
    if (addr == CAP_SEL)
      rdData[TB_W-1:0] = capValue;
    else
      rdData = statWord;
  end

endmodule

// File: rtl/pwm_stat_chk.sv
module pwm_stat_chk #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int TB_W      = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wrData,
  input logic              enable,
  input logic              syncIn,
  input logic              faultIn,
  input logic              climIn,
  input logic              ffwdIn,
  input logic              cycleEnd,
  input logic              pushPull,
  input logic              startReq,
  input logic              stopReq,
  input logic              loadStrobe,
  input logic              dataLock,
  input logic [TB_W-1:0]   capValue,
  input logic [15:0]       statWord
);

  logic statWrite;
  logic prevSync;
  logic prevFault;

  assign statWrite = sel && wrEn && (addr == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSync  <= 1'b0;
      prevFault <= 1'b0;
    end else begin
      prevSync  <= syncIn;
      prevFault <= faultIn;
    end
  end

  p_sync_evt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && syncIn && !prevSync) |=> statWord[15]);

  p_fault_evt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && faultIn && !prevFault) |=> statWord[14]);

  p_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    statWord[11:8] == {syncIn, faultIn, climIn, ffwdIn});

  p_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && wrData[7] && !wrData[6]) |=> (startReq && statWord[0]));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && wrData[6]) |=> (stopReq && !startReq && !statWord[0]));

  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statWord[5] && !statWrite) |=> $stable(capValue));

  p_upd_lock_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && wrData[3]) |=> (statWord[4] && dataLock));

  p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statWord[4] && cycleEnd) |=> (loadStrobe && !dataLock));

  p_steer_r11: assert property (@(posedge clk) disable iff (!rstN)
    !pushPull |=> !statWord[2]);

endmodule

bind pwm_stat_reg pwm_stat_chk #(
  .ADDR_W    (ADDR_W),
  .STAT_ADDR (STAT_ADDR),
  .TB_W      (TB_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sel        (sel),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .enable     (enable),
  .syncIn     (syncIn),
  .faultIn    (faultIn),
  .climIn     (climIn),
  .ffwdIn     (ffwdIn),
  .cycleEnd   (cycleEnd),
  .pushPull   (pushPull),
  .startReq   (startReq),
  .stopReq    (stopReq),
  .loadStrobe (loadStrobe),
  .dataLock   (dataLock),
  .capValue   (capValue),
  .statWord   (statWord)
);

// File: tb/pwm_stat_reg_test.sv
`timescale 1ns/1ps
module pwm_stat_reg_test;

  localparam int ADDR_W = 4;
  localparam int TB_W   = 16;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_CAP  = 4'd1;

  // kinds of observed output
  localparam int K_RD    = 0;
  localparam int K_START = 1;
  localparam int K_STOP  = 2;
  localparam int K_LOAD  = 3;
  localparam int K_LOCK  = 4;
  localparam int K_CAPV  = 5;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0, wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic enable = 1'b0;
  logic syncIn = 1'b0, faultIn = 1'b0, climIn = 1'b0, ffwdIn = 1'b0;
  logic cycleEnd = 1'b0, pushPull = 1'b0, centerMode = 1'b0, halfIn = 1'b0;
  logic [TB_W-1:0] timeBase = '0;
  logic startReq, stopReq, loadStrobe, dataLock;
  logic [TB_W-1:0] capValue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sbq[$];

  always #5 clk = ~clk;

  pwm_stat_reg #(.ADDR_W(ADDR_W), .TB_W(TB_W)) uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .enable(enable),
    .syncIn(syncIn), .faultIn(faultIn), .climIn(climIn), .ffwdIn(ffwdIn),
    .cycleEnd(cycleEnd), .pushPull(pushPull), .centerMode(centerMode),
    .halfIn(halfIn), .timeBase(timeBase), .startReq(startReq),
    .stopReq(stopReq), .loadStrobe(loadStrobe), .dataLock(dataLock),
    .capValue(capValue)
  );

  // Monitor: pops one expected item per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sbq.pop_front();
        case (it.kind)
          K_START: act = {15'd0, startReq};
          K_STOP:  act = {15'd0, stopReq};
          K_LOAD:  act = {15'd0, loadStrobe};
          K_LOCK:  act = {15'd0, dataLock};
          K_CAPV:  act = capValue;
          default: act = rdData;
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expectOut(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic readCheck(logic [ADDR_W-1:0] a, logic [15:0] exp, string tag);
    addr = a;
    expectOut(K_RD, exp, tag);
  endtask

  task automatic busWrite(logic [15:0] d);
    sel = 1'b1; wrEn = 1'b1; addr = A_STAT; wrData = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseEnd();
    cycleEnd = 1'b1;
    tick();
    cycleEnd = 1'b0;
  endtask

  initial begin
    timeBase = 16'h1234;
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset values
    readCheck(A_STAT, 16'h0000, "R1 status");
    expectOut(K_CAPV, 16'h0000, "R1 capValue");
    expectOut(K_LOCK, 16'h0000, "R1 dataLock");

    // R3 live levels, R2 no event while disabled
    faultIn = 1'b1; climIn = 1'b1;
    tick();
    readCheck(A_STAT, 16'h0600, "R3 live/R2 disabled");
    // R2 high at enable
    enable = 1'b1;
    tick();
    readCheck(A_STAT, 16'h6600, "R2 high at enable");
    // R2 rising edge
    syncIn = 1'b1;
    tick();
    readCheck(A_STAT, 16'hEE00, "R2 rising edge");
    // R4 write 0 clears, write 1 keeps
    busWrite(16'hA000);
    readCheck(A_STAT, 16'hAE00, "R4 partial clear");
    // R4 set wins over clear
    ffwdIn = 1'b1;
    busWrite(16'h0000);
    readCheck(A_STAT, 16'h1F00, "R4 set wins");
    syncIn = 1'b0; faultIn = 1'b0; climIn = 1'b0; ffwdIn = 1'b0;
    readCheck(A_STAT, 16'h1000, "R3 inputs low");
    enable = 1'b0;
    syncIn = 1'b1;
    tick();
    readCheck(A_STAT, 16'h1800, "R2 edge ignored when disabled");
    syncIn = 1'b0;
    busWrite(16'h0000);
    readCheck(A_STAT, 16'h0000, "R4 clear all");
    enable = 1'b1;

    // R5 / R6 trigger commands
    busWrite(16'h0080);
    expectOut(K_START, 16'h0001, "R5 startReq");
    readCheck(A_STAT, 16'h0001, "R5 trig set");
    busWrite(16'h0040);
    expectOut(K_STOP, 16'h0001, "R6 stopReq");
    readCheck(A_STAT, 16'h0000, "R6 trig clear");
    busWrite(16'h0080);
    readCheck(A_STAT, 16'h0001, "R5 trig set again");
    busWrite(16'h00C0);
    expectOut(K_STOP, 16'h0001, "R6 both: stop");
    readCheck(A_STAT, 16'h0000, "R6 both: stop wins");

    // R7 capture
    busWrite(16'h0020);
    timeBase = 16'h5678;
    tick();
    expectOut(K_CAPV, 16'h5678, "R7 capValue");
    readCheck(A_STAT, 16'h0020, "R7 cap flag");
    readCheck(A_CAP, 16'h5678, "R7 capture address");
    // R8 lockout
    timeBase = 16'h9999;
    busWrite(16'h0020);
    tick();
    tick();
    expectOut(K_CAPV, 16'h5678, "R8 lockout");
    readCheck(A_STAT, 16'h0020, "R8 flag held");
    busWrite(16'h0000);
    readCheck(A_STAT, 16'h0000, "R8 cleared");
    busWrite(16'h0020);
    timeBase = 16'hABCD;
    tick();
    expectOut(K_CAPV, 16'hABCD, "R7 recapture");
    busWrite(16'h0000);

    // R9 / R10 update
    busWrite(16'h0008);
    expectOut(K_LOCK, 16'h0001, "R9 dataLock");
    readCheck(A_STAT, 16'h0010, "R9 pending bit");
    pulseEnd();
    expectOut(K_LOAD, 16'h0001, "R10 loadStrobe");
    expectOut(K_LOCK, 16'h0000, "R10 lock released");
    readCheck(A_STAT, 16'h0000, "R10 pending cleared");
    pulseEnd();
    expectOut(K_LOAD, 16'h0000, "R10 no load when idle");

    // R11 steering
    pushPull = 1'b1;
    pulseEnd();
    readCheck(A_STAT, 16'h0004, "R11 toggle 1");
    pulseEnd();
    readCheck(A_STAT, 16'h0000, "R11 toggle 0");
    pulseEnd();
    readCheck(A_STAT, 16'h0004, "R11 toggle 1 again");
    pushPull = 1'b0;
    tick();
    readCheck(A_STAT, 16'h0000, "R11 cleared off mode");
    pulseEnd();
    readCheck(A_STAT, 16'h0000, "R11 no toggle off mode");

    // R12 half cycle
    centerMode = 1'b1; halfIn = 1'b1;
    tick();
    readCheck(A_STAT, 16'h0002, "R12 half set");
    centerMode = 1'b0;
    tick();
    readCheck(A_STAT, 16'h0000, "R12 gated off");

    tick();
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule